// File: doc/BRIEF.md
# Dual-Port GPIO Interrupt-on-Change Unit

This block owns two 8-bit general-purpose ports, A and B. Each port has its own direction, output latch, input polarity, interrupt enable, trigger mode, default-value and pull-up enable registers. All of them sit behind a small register bus with a write strobe, a read strobe and combinational read data.

Input pins pass through a two-flop synchroniser. Each synchronised bit is then XORed with its polarity bit. For every enabled pin, the block compares the result either with its value one clock earlier (change mode) or with a programmed default bit (compare mode). The first hit on a port latches two things: a per-pin flag word and a snapshot of the whole port. Both stay frozen until software reads the capture or port-data register. That read releases them and drops the interrupt.

Each port drives its own interrupt line, and a control bit can merge the two lines. A shared control register selects the line drive: active-low push-pull, active-high push-pull, or open-drain. Open-drain is modelled as an output enable plus a data value of 0.

Top module: `gpio_ioc_unit`

## Requirements
- R1: After reset every direction bit is 1 (input), so `pin_oe` is all 0. The control register reads 0, and both interrupt lines are inactive: `int_o` = 2'b11 and `int_oe` = 2'b11 under the default active-low push-pull drive.
- R2: Reading the port-data register (select 8) returns the pin values XOR the polarity register (select 1). The value reflects a pin change two clock edges after the pin moves.
- R3: In change mode (mode bit 0), an enabled pin sets its flag on the edge after its polarity-adjusted value differs from the value one clock earlier. A pin whose enable bit (select 2) is 0 never sets a flag or raises an interrupt.
- R4: In compare mode (mode register, select 3, bit = 1), an enabled pin sets its flag while its polarity-adjusted value differs from the default-value register (select 4).
- R5: When a port's flag word goes from zero to non-zero, the capture register (select 7) latches the polarity-adjusted port value. While the flag word is non-zero, later pin activity changes neither the flags (select 6) nor the capture.
- R6: Reading the capture or the port-data register of a port clears that port's flags and its interrupt at that edge. Reading the flag register does not clear them. In compare mode, a mismatch that still holds sets the flags again one clock later.
- R7: Port A raises `int_o[0]` and port B raises `int_o[1]`. When control bit 0 (merge) is 1, both lines assert if either port has a flag set.
- R8: Control bit 2 = 1 selects open-drain: `int_oe[k]` is high only while line k asserts, and `int_o[k]` is 0. Otherwise `int_oe` is 1, and `int_o[k]` equals the asserted state when control bit 1 is 1 and its inverse when it is 0. Bit 2 overrides bit 1.
- R9: A write to the output latch (select 9) appears on `pin_o`. `pin_oe[i]` is the inverse of direction bit i (select 0), and reading the latch returns the written value.
- R10: Registers at selects 0–5 and 9 read back what was written. The pull-up register (select 5) affects neither pins nor interrupts. The register address is {select[3:0], port}: port 0 is A, and the control register is select 10 for either port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (triggers read-to-clear) |
| reg_addr | input | 5 | {select, port} register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the address |
| pin_i | input | 16 | Pin inputs, port B in the upper byte |
| pin_o | output | 16 | Pin output values from the latches |
| pin_oe | output | 16 | Pin output enables |
| int_o | output | 2 | Interrupt line data, index 0 for port A |
| int_oe | output | 2 | Interrupt line output enables |

## Verification
Random pin words under random polarity masks test the XOR path into the data register; a missing inversion or a wrong byte lane shows up at once. Change mode is tried with toggles on a disabled pin and then on an enabled pin. This separates enable gating from detection, and a further toggle while the flags are held shows whether capture freezes. Compare mode runs with random default and pin bytes, including an equal pair, so that the flag word must equal their XOR exactly. A persistent mismatch then shows the clear on read and the reassertion one clock later. The same held mismatch is run through every control setting, which separates line merging, polarity and open-drain behaviour.

// File: rtl/gpio_ioc_pkg.sv
package gpio_ioc_pkg;
    localparam int SEL_W  = 4;
    localparam int ADDR_W = SEL_W + 1;
    localparam int NPORT  = 2;
    localparam int CTRL_W = 3;

    localparam int CTRL_MERGE = 0;
    localparam int CTRL_ACTHI = 1;
    localparam int CTRL_ODR   = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_DIR   = 4'd0,
        SEL_POL   = 4'd1,
        SEL_IEN   = 4'd2,
        SEL_MODE  = 4'd3,
        SEL_DEFV  = 4'd4,
        SEL_PULL  = 4'd5,
        SEL_FLAG  = 4'd6,
        SEL_CAPT  = 4'd7,
        SEL_PORT  = 4'd8,
        SEL_LATCH = 4'd9,
        SEL_CTRL  = 4'd10
    } sel_e;
endpackage

// File: rtl/gpio_ioc_sync.sv
module gpio_ioc_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.s2;
endmodule

// File: rtl/gpio_ioc_port.sv
module gpio_ioc_port
    import gpio_ioc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic [SEL_W-1:0] sel,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] rdata,
    output logic [W-1:0] flag,
    output logic [W-1:0] capt,
    output logic [W-1:0] latch,
    output logic [W-1:0] dir
);
    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] pol;
        logic [W-1:0] ien;
        logic [W-1:0] mode;
        logic [W-1:0] defv;
        logic [W-1:0] pull;
        logic [W-1:0] flag;
        logic [W-1:0] capt;
        logic [W-1:0] latch;
        logic [W-1:0] prev;
    } port_t;

    port_t        st_d, st_q;
    logic [W-1:0] in_val;
    logic [W-1:0] hit;
    logic         clr;

    always_comb begin
        in_val = pin_sync ^ st_q.pol;
        hit    = st_q.ien & ((st_q.mode & (in_val ^ st_q.defv)) |
                             (~st_q.mode & (in_val ^ st_q.prev)));
        clr    = rd_en && ((sel == SEL_CAPT) || (sel == SEL_PORT));

        st_d      = st_q;
        st_d.prev = in_val;

        if (clr) begin
            st_d.flag = '0;
        end else if ((st_q.flag == '0) && (hit != '0)) begin
            st_d.flag = hit;
            st_d.capt = in_val;
        end

        if (wr_en) begin
            case (sel)
                SEL_DIR:   st_d.dir   = wdata;
                SEL_POL:   st_d.pol   = wdata;
                SEL_IEN:   st_d.ien   = wdata;
                SEL_MODE:  st_d.mode  = wdata;
                SEL_DEFV:  st_d.defv  = wdata;
                SEL_PULL:  st_d.pull  = wdata;
                SEL_LATCH: st_d.latch = wdata;
                default:   ;
            endcase
        end

        case (sel)
            SEL_DIR:   rdata = st_q.dir;
            SEL_POL:   rdata = st_q.pol;
            SEL_IEN:   rdata = st_q.ien;
            SEL_MODE:  rdata = st_q.mode;
            SEL_DEFV:  rdata = st_q.defv;
            SEL_PULL:  rdata = st_q.pull;
            SEL_FLAG:  rdata = st_q.flag;
            SEL_CAPT:  rdata = st_q.capt;
            SEL_PORT:  rdata = in_val;
            SEL_LATCH: rdata = st_q.latch;
            default:   rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.dir <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag  = st_q.flag;
    assign capt  = st_q.capt;
    assign latch = st_q.latch;
    assign dir   = st_q.dir;
endmodule

// File: rtl/gpio_ioc_irq_out.sv
module gpio_ioc_irq_out
    import gpio_ioc_pkg::*;
(
    input  logic [NPORT-1:0] raw,
    input  logic             merge,
    input  logic             act_hi,
    input  logic             odr,
    output logic [NPORT-1:0] int_o,
    output logic [NPORT-1:0] int_oe
);
    for (genvar k = 0; k < NPORT; k++) begin : g_line
        logic line;
        always_comb begin
            line      = merge ? (|raw) : raw[k];
            int_oe[k] = odr ? line : 1'b1;
            int_o[k]  = odr ? 1'b0 : (act_hi ? line : ~line);
        end
    end
endmodule

// File: rtl/gpio_ioc_unit.sv
module gpio_ioc_unit
    import gpio_ioc_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_we,
    input  logic                      reg_re,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [PORT_W-1:0]         reg_wdata,
    output logic [PORT_W-1:0]         reg_rdata,
    input  logic [NPORT*PORT_W-1:0]   pin_i,
    output logic [NPORT*PORT_W-1:0]   pin_o,
    output logic [NPORT*PORT_W-1:0]   pin_oe,
    output logic [NPORT-1:0]          int_o,
    output logic [NPORT-1:0]          int_oe
);
    localparam int TOT_W = NPORT * PORT_W;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
    } top_t;

    top_t                              st_d, st_q;
    logic [SEL_W-1:0]                  sel;
    logic                              psel;
    logic [TOT_W-1:0]                  pin_sync;
    logic [NPORT-1:0][PORT_W-1:0]      prd;
    logic [NPORT-1:0][PORT_W-1:0]      flag_vec;
    logic [NPORT-1:0][PORT_W-1:0]      capt_vec;
    logic [NPORT-1:0][PORT_W-1:0]      latch_vec;
    logic [NPORT-1:0][PORT_W-1:0]      dir_vec;
    logic [NPORT-1:0]                  raw;

    assign sel  = reg_addr[ADDR_W-1:1];
    assign psel = reg_addr[0];

    gpio_ioc_sync #(.W(TOT_W)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (pin_i),
        .q_o  (pin_sync)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic hit_me;
        assign hit_me = (psel == p[0]) && (sel != SEL_CTRL);

        gpio_ioc_port #(.W(PORT_W)) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (reg_we && hit_me),
            .rd_en   (reg_re && hit_me),
            .sel     (sel),
            .wdata   (reg_wdata),
            .pin_sync(pin_sync[p*PORT_W +: PORT_W]),
            .rdata   (prd[p]),
            .flag    (flag_vec[p]),
            .capt    (capt_vec[p]),
            .latch   (latch_vec[p]),
            .dir     (dir_vec[p])
        );

        assign pin_o[p*PORT_W +: PORT_W]  = latch_vec[p];
        assign pin_oe[p*PORT_W +: PORT_W] = ~dir_vec[p];
        assign raw[p]                     = |flag_vec[p];
    end

    always_comb begin
        st_d = st_q;
        if (reg_we && (sel == SEL_CTRL)) st_d.ctrl = reg_wdata[CTRL_W-1:0];

        if (sel == SEL_CTRL) reg_rdata = {{(PORT_W-CTRL_W){1'b0}}, st_q.ctrl};
        else                 reg_rdata = prd[psel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    gpio_ioc_irq_out u_irq (
        .raw   (raw),
        .merge (st_q.ctrl[CTRL_MERGE]),
        .act_hi(st_q.ctrl[CTRL_ACTHI]),
        .odr   (st_q.ctrl[CTRL_ODR]),
        .int_o (int_o),
        .int_oe(int_oe)
    );
endmodule

// File: rtl/gpio_ioc_checker.sv
module gpio_ioc_checker
    import gpio_ioc_pkg::*;
#(
    parameter int W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic              reg_re,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [W-1:0]      reg_wdata,
    input logic [2*W-1:0]    pin_o,
    input logic [2*W-1:0]    pin_oe,
    input logic [W-1:0]      flag_a,
    input logic [W-1:0]      capt_a
);
    logic rd_clr_a;
    assign rd_clr_a = reg_re && !reg_addr[0] &&
                      ((reg_addr[ADDR_W-1:1] == SEL_CAPT) || (reg_addr[ADDR_W-1:1] == SEL_PORT));

    AST_RESET_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0)); // R1

    AST_FROZEN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_a != '0) && !rd_clr_a |=> $stable(capt_a) && (flag_a == $past(flag_a))); // R5

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr_a |=> (flag_a == '0)); // R6

    AST_LATCH_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && (reg_addr == {SEL_LATCH, 1'b0}) |=> (pin_o[W-1:0] == $past(reg_wdata))); // R9

    AST_DIR_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && (reg_addr == {SEL_DIR, 1'b1}) |=> (pin_oe[2*W-1:W] == ~$past(reg_wdata))); // R9
endmodule

bind gpio_ioc_unit gpio_ioc_checker #(.W(PORT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_re   (reg_re),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .pin_o    (pin_o),
    .pin_oe   (pin_oe),
    .flag_a   (flag_vec[0]),
    .capt_a   (capt_vec[0])
);

// File: tb/gpio_ioc_unit_bench.sv
module gpio_ioc_unit_bench;
    import gpio_ioc_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [15:0] pins = '0;
    logic [15:0] pin_o, pin_oe;
    logic [1:0]  int_o, int_oe;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_ioc_unit u_gpio_ioc_unit (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_i(pins), .pin_o(pin_o), .pin_oe(pin_oe),
        .int_o(int_o), .int_oe(int_oe)
    );

    function automatic logic [4:0] ad(input sel_e s, input bit p);
        return {s, p};
    endfunction

    function automatic logic [7:0] exp_port(input logic [7:0] p, input logic [7:0] pol);
        return p ^ pol;
    endfunction

    function automatic logic [7:0] exp_cmp_flags(input logic [7:0] v, input logic [7:0] d, input logic [7:0] en);
        return (v ^ d) & en;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_re = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, p, d, pol_a, pol_b;
        void'($urandom(32'h5eed_1234));

        idle(3);
        // R1: reset state
        check("R1 pin_oe", pin_oe, 16'h0000);
        check("R1 int_o", {14'd0, int_o}, 16'h0003);
        check("R1 int_oe", {14'd0, int_oe}, 16'h0003);
        rst_n = 1'b1;
        idle(1);
        rd(ad(SEL_DIR, 0), v);   check("R1 dir A", {8'd0, v}, 16'h00ff);
        rd(ad(SEL_CTRL, 0), v);  check("R1 ctrl", {8'd0, v}, 16'h0000);

        // R9: latch and direction
        wr(ad(SEL_DIR, 0), 8'h0f);
        wr(ad(SEL_LATCH, 0), 8'ha5);
        check("R9 pin_oe", pin_oe, 16'h00f0);
        check("R9 pin_o", pin_o, 16'h00a5);
        rd(ad(SEL_LATCH, 0), v); check("R9 latch read", {8'd0, v}, 16'h00a5);
        wr(ad(SEL_DIR, 0), 8'hff);

        // R10: readback and pull-up has no effect
        for (int i = 0; i < 6; i++) begin
            d = 8'($urandom);
            wr(ad(SEL_PULL, i[0]), d);
            rd(ad(SEL_PULL, i[0]), v); check("R10 pull readback", {8'd0, v}, {8'd0, d});
            d = 8'($urandom);
            wr(ad(SEL_DEFV, i[0]), d);
            rd(ad(SEL_DEFV, i[0]), v); check("R10 defv readback", {8'd0, v}, {8'd0, d});
            check("R10 pull no oe effect", pin_oe, 16'h0000);
            check("R10 pull no int effect", {14'd0, int_o}, 16'h0003);
        end

        // R2: random pins and polarity
        for (int i = 0; i < 20; i++) begin
            pol_a = 8'($urandom); pol_b = 8'($urandom);
            wr(ad(SEL_POL, 0), pol_a);
            wr(ad(SEL_POL, 1), pol_b);
            pins = 16'($urandom);
            idle(2);
            rd(ad(SEL_PORT, 0), v); check("R2 port A", {8'd0, v}, {8'd0, exp_port(pins[7:0], pol_a)});
            rd(ad(SEL_PORT, 1), v); check("R2 port B", {8'd0, v}, {8'd0, exp_port(pins[15:8], pol_b)});
        end
        wr(ad(SEL_POL, 0), 8'h00);
        wr(ad(SEL_POL, 1), 8'h00);
        pins = 16'h0000;
        idle(3);

        // R3 / R5 / R6: change mode on port A, only bit 0 enabled
        wr(ad(SEL_IEN, 0), 8'h01);
        pins[7:0] = 8'h08;
        idle(3);
        check("R3 disabled pin no irq", {14'd0, int_o}, 16'h0003);
        rd(ad(SEL_FLAG, 0), v); check("R3 disabled pin no flag", {8'd0, v}, 16'h0000);
        pins[7:0] = 8'h09;
        idle(3);
        check("R3 enabled change irq", {15'd0, int_o[0]}, 16'h0000);
        pins[7:0] = 8'h0a;
        idle(3);
        rd(ad(SEL_FLAG, 0), v); check("R5 flag frozen", {8'd0, v}, 16'h0001);
        check("R6 flag read keeps irq", {15'd0, int_o[0]}, 16'h0000);
        rd(ad(SEL_CAPT, 0), v); check("R5 capture frozen", {8'd0, v}, 16'h0009);
        check("R6 capture read clears irq", {15'd0, int_o[0]}, 16'h0001);
        idle(2);
        rd(ad(SEL_FLAG, 0), v); check("R6 change mode stays clear", {8'd0, v}, 16'h0000);
        wr(ad(SEL_IEN, 0), 8'h00);

        // R4 / R5: compare mode on port B, random patterns
        wr(ad(SEL_MODE, 1), 8'hff);
        for (int i = 0; i < 16; i++) begin
            wr(ad(SEL_IEN, 1), 8'h00);
            rd(ad(SEL_PORT, 1), v);
            d = 8'($urandom);
            p = (i == 0) ? d : 8'($urandom);
            wr(ad(SEL_DEFV, 1), d);
            pins[15:8] = p;
            idle(3);
            wr(ad(SEL_IEN, 1), 8'hff);
            idle(1);
            rd(ad(SEL_FLAG, 1), v);
            check("R4 compare flags", {8'd0, v}, {8'd0, exp_cmp_flags(p, d, 8'hff)});
            check("R4 compare irq", {15'd0, int_o[1]}, {15'd0, (p == d)});
            if (p != d) begin
                rd(ad(SEL_CAPT, 1), v); check("R5 capture value", {8'd0, v}, {8'd0, p});
            end
        end

        // R6: persistent mismatch re-asserts after read
        wr(ad(SEL_IEN, 1), 8'h00);
        rd(ad(SEL_PORT, 1), v);
        wr(ad(SEL_DEFV, 1), 8'h00);
        pins[15:8] = 8'h01;
        idle(3);
        wr(ad(SEL_IEN, 1), 8'hff);
        idle(1);
        check("R6 mismatch asserted", {15'd0, int_o[1]}, 16'h0000);
        rd(ad(SEL_PORT, 1), v);
        check("R6 port read clears", {15'd0, int_o[1]}, 16'h0001);
        idle(1);
        check("R6 re-assert", {15'd0, int_o[1]}, 16'h0000);

        // R7: line routing and merge
        check("R7 separate lines", {14'd0, int_o}, 16'h0001);
        wr(ad(SEL_CTRL, 0), 8'h01);
        check("R7 merged lines", {14'd0, int_o}, 16'h0000);

        // R8: drive modes
        wr(ad(SEL_CTRL, 1), 8'h02);
        check("R8 active high", {14'd0, int_o}, 16'h0002);
        check("R8 active high oe", {14'd0, int_oe}, 16'h0003);
        wr(ad(SEL_CTRL, 0), 8'h04);
        check("R8 open drain oe", {14'd0, int_oe}, 16'h0002);
        check("R8 open drain data", {14'd0, int_o}, 16'h0000);
        wr(ad(SEL_CTRL, 0), 8'h06);
        check("R8 odr overrides", {14'd0, int_oe}, 16'h0002);
        wr(ad(SEL_CTRL, 0), 8'h05);
        check("R8 odr merged", {14'd0, int_oe}, 16'h0003);
        wr(ad(SEL_CTRL, 0), 8'h00);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule